// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block is the coherence engine for one core's small write-back cache that sits on a shared snooping bus with write-invalidate semantics. It keeps a direct-mapped tag and state store in which each line is Invalid, Shared or Modified. It turns the core's loads and stores into bus transactions: read, read-for-ownership, upgrade and write-back. It also watches the requests that other cores place on the bus and changes its own lines to match.

A bus transaction is atomic. The controller raises its request and keeps command and address steady. It counts the transaction as finished only in the cycle in which the arbiter's grant and the all-snoopers-acknowledged signal are both high, so a store cannot finish before this core owns the bus. Only a store to a Shared line broadcasts an upgrade. A store to a Modified line finishes locally. When another core asks for a line held Modified, this controller flags that it supplies the dirty data. A remote read also triggers a write-back to memory.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high and `bus_req`, `cpu_done` and `snp_ack` are low, so the first access to any address goes to the bus.
- R2: A load that misses issues a bus read of the line address and leaves the line Shared. `cpu_done` pulses for one cycle, in the cycle after the completing grant-and-acknowledge cycle. A later load to the line completes with no bus request.
- R3: A store that misses issues a read-for-ownership and leaves the line Modified.
- R4: A store to a Shared line issues an upgrade and leaves the line Modified.
- R5: A load or store that hits a Modified line issues no bus request and raises `cpu_done` in the cycle after it is accepted.
- R6: Once raised, `bus_req` stays high with a steady `bus_addr` until a cycle in which `bus_gnt` and `bus_ack_all` are both high. The core's access does not complete before that cycle.
- R7: A snooped read that hits a Modified line raises both `snp_supply` and `snp_wb` in the following cycle and leaves the line Shared, so a later store issues an upgrade.
- R8: A snooped read-for-ownership or upgrade that hits a valid line makes it Invalid, and a later load issues a bus read. `snp_supply` is raised only if the line was Modified, and `snp_wb` stays low.
- R9: A snooped read that hits a Shared line, and any snoop that misses, leave the store unchanged. `snp_supply` and `snp_wb` stay low.
- R10: A miss whose frame holds a Modified line of another tag first issues a write-back of that victim's address and then issues the fill. A Shared victim is dropped with no bus traffic.
- R11: `snp_ack` is high exactly in the cycle after each cycle with `snp_valid` high.
- R12: Bus command codes are read 00, read-for-ownership 01, upgrade 10 and write-back 11. Line states are coded Invalid 00, Shared 01 and Modified 10.
- R13: If a snoop invalidates a Shared line while this core's upgrade for it is still waiting for the bus, the pending request becomes a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Core presents an access |
| cpu_req_write | input | 1 | 1 for store, 0 for load |
| cpu_req_addr | input | LINE_AW | Line address of the access |
| cpu_req_ready | output | 1 | Controller can accept an access |
| cpu_done | output | 1 | One-cycle pulse when the access completes |
| bus_req | output | 1 | Request for the shared bus |
| bus_cmd | output | 2 | Command of the pending transaction |
| bus_addr | output | LINE_AW | Line address of the pending transaction |
| bus_gnt | input | 1 | Arbiter grants the bus to this core |
| bus_ack_all | input | 1 | All other snoopers have acknowledged |
| snp_valid | input | 1 | Another core's transaction is visible |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | LINE_AW | Line address of the snooped transaction |
| snp_ack | output | 1 | Receipt of the snoop |
| snp_supply | output | 1 | This cache provides the dirty line data |
| snp_wb | output | 1 | Dirty data is also written back to memory |

## Verification
The assertions assume that the bus is atomic. A snoop never arrives in a cycle in which this core is granted, and a snooped upgrade never targets a line this core holds Modified. The request-stability property is not applied in a cycle that follows a snoop, because a snoop may legally change the pending command or cancel a write-back. The stimulus drives snoops only between the core's transactions, or while a request is still waiting for grant. It raises grant and acknowledge together for a single cycle after some wait cycles, and it leaves each core access in place until `cpu_done`.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'b00,
        LN_S = 2'b01,
        LN_M = 2'b10
    } line_st_e;

    typedef enum logic [1:0] {
        BC_RD  = 2'b00,
        BC_RDX = 2'b01,
        BC_UPG = 2'b10,
        BC_WB  = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'b00,
        CS_EVICT = 2'b01,
        CS_FILL  = 2'b10,
        CS_DONE  = 2'b11
    } ctl_st_e;

endpackage

// File: rtl/msi_tag_array.sv
module msi_tag_array
    import msi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic [TAG_W-1:0] a_tag,
    output line_st_e         a_st,
    input  logic [IDX_W-1:0] b_idx,
    output logic [TAG_W-1:0] b_tag,
    output line_st_e         b_st,
    input  logic             w_en,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [TAG_W-1:0] w_tag,
    input  line_st_e         w_st
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    line_st_e         st_q  [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[s] <= '0;
                st_q[s]  <= LN_I;
            end else if (w_en && (w_idx == IDX_W'(s))) begin
                tag_q[s] <= w_tag;
                st_q[s]  <= w_st;
            end
        end
    end

    assign a_tag = tag_q[a_idx];
    assign a_st  = st_q[a_idx];
    assign b_tag = tag_q[b_idx];
    assign b_st  = st_q[b_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
(
    input  logic     valid,
    input  logic     hit,
    input  bus_cmd_e cmd,
    input  line_st_e cur_st,
    output logic     upd,
    output line_st_e new_st,
    output logic     supply,
    output logic     wb
);
    always_comb begin
        upd    = 1'b0;
        new_st = cur_st;
        supply = 1'b0;
        wb     = 1'b0;
        if (valid && hit) begin
            unique case (cmd)
                BC_RD: begin
                    if (cur_st == LN_M) begin
                        upd    = 1'b1;
                        new_st = LN_S;
                        supply = 1'b1;
                        wb     = 1'b1;
                    end
                end
                BC_RDX, BC_UPG: begin
                    upd    = 1'b1;
                    new_st = LN_I;
                    supply = (cur_st == LN_M);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int LINE_AW = 12,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req_valid,
    input  logic               cpu_req_write,
    input  logic [LINE_AW-1:0] cpu_req_addr,
    output logic               cpu_req_ready,
    output logic               cpu_done,
    output logic               bus_req,
    output logic [1:0]         bus_cmd,
    output logic [LINE_AW-1:0] bus_addr,
    input  logic               bus_gnt,
    input  logic               bus_ack_all,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [LINE_AW-1:0] snp_addr,
    output logic               snp_ack,
    output logic               snp_supply,
    output logic               snp_wb
);
    localparam int TAG_W = LINE_AW - IDX_W;

    typedef struct packed {
        ctl_st_e            st;
        logic               wr;
        logic [LINE_AW-1:0] addr;
        logic               ack;
        logic               sup;
        logic               wb;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0] a_idx, snp_idx, req_idx;
    logic [TAG_W-1:0] a_tag, b_tag, look_tag, req_tag, snp_tag;
    line_st_e         a_st, b_st;
    logic             a_hit, b_hit;

    logic             arr_we;
    logic [IDX_W-1:0] arr_idx;
    logic [TAG_W-1:0] arr_tag;
    line_st_e         arr_st;

    logic             su_upd, su_sup, su_wb;
    line_st_e         su_st;
    logic             xfer_done;

    assign req_idx  = q.addr[IDX_W-1:0];
    assign req_tag  = q.addr[LINE_AW-1:IDX_W];
    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[LINE_AW-1:IDX_W];
    assign a_idx    = (q.st == CS_IDLE) ? cpu_req_addr[IDX_W-1:0] : req_idx;
    assign look_tag = (q.st == CS_IDLE) ? cpu_req_addr[LINE_AW-1:IDX_W] : req_tag;
    assign a_hit    = (a_st != LN_I) && (a_tag == look_tag);
    assign b_hit    = (b_st != LN_I) && (b_tag == snp_tag);
    assign xfer_done = bus_gnt && bus_ack_all;

    msi_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .a_idx (a_idx),
        .a_tag (a_tag),
        .a_st  (a_st),
        .b_idx (snp_idx),
        .b_tag (b_tag),
        .b_st  (b_st),
        .w_en  (arr_we),
        .w_idx (arr_idx),
        .w_tag (arr_tag),
        .w_st  (arr_st)
    );

    msi_snoop_unit u_snoop (
        .valid  (snp_valid),
        .hit    (b_hit),
        .cmd    (bus_cmd_e'(snp_cmd)),
        .cur_st (b_st),
        .upd    (su_upd),
        .new_st (su_st),
        .supply (su_sup),
        .wb     (su_wb)
    );

    always_comb begin
        d       = q;
        d.ack   = snp_valid;
        d.sup   = su_sup;
        d.wb    = su_wb;
        arr_we  = su_upd;
        arr_idx = snp_idx;
        arr_tag = b_tag;
        arr_st  = su_st;
        bus_req  = 1'b0;
        bus_cmd  = BC_RD;
        bus_addr = q.addr;
        unique case (q.st)
            CS_IDLE: begin
                if (cpu_req_valid) begin
                    d.wr   = cpu_req_write;
                    d.addr = cpu_req_addr;
                    if (a_hit && (!cpu_req_write || a_st == LN_M)) begin
                        d.st = CS_DONE;
                    end else if (a_st == LN_M && !a_hit) begin
                        d.st = CS_EVICT;
                    end else begin
                        d.st = CS_FILL;
                    end
                end
            end
            CS_EVICT: begin
                if (a_st == LN_M && !a_hit) begin
                    bus_req  = 1'b1;
                    bus_cmd  = BC_WB;
                    bus_addr = {a_tag, req_idx};
                    if (xfer_done) begin
                        arr_we  = 1'b1;
                        arr_idx = req_idx;
                        arr_tag = a_tag;
                        arr_st  = LN_I;
                        d.st    = CS_FILL;
                    end
                end else begin
                    d.st = CS_FILL;
                end
            end
            CS_FILL: begin
                bus_req = 1'b1;
                if (!q.wr) begin
                    bus_cmd = BC_RD;
                end else if (a_hit && a_st == LN_S) begin
                    bus_cmd = BC_UPG;
                end else begin
                    bus_cmd = BC_RDX;
                end
                if (xfer_done) begin
                    arr_we  = 1'b1;
                    arr_idx = req_idx;
                    arr_tag = req_tag;
                    arr_st  = q.wr ? LN_M : LN_S;
                    d.st    = CS_DONE;
                end
            end
            CS_DONE: d.st = CS_IDLE;
            default: d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: CS_IDLE, wr: 1'b0, addr: '0, ack: 1'b0, sup: 1'b0, wb: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cpu_req_ready = (q.st == CS_IDLE);
    assign cpu_done      = (q.st == CS_DONE);
    assign snp_ack       = q.ack;
    assign snp_supply    = q.sup;
    assign snp_wb        = q.wb;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int LINE_AW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req_ready,
    input logic               cpu_done,
    input logic               bus_req,
    input logic [1:0]         bus_cmd,
    input logic [LINE_AW-1:0] bus_addr,
    input logic               bus_gnt,
    input logic               bus_ack_all,
    input logic               snp_valid,
    input logic               snp_ack,
    input logic               snp_supply,
    input logic               snp_wb
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !(bus_gnt && bus_ack_all) && !snp_valid |=> bus_req && $stable(bus_addr)); // R6
    AST_NOT_READY_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_req_ready); // R6
    AST_FILL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && bus_ack_all && bus_cmd != 2'b11 |=> cpu_done); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R5
    AST_SNOOP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_ack); // R11
    AST_ACK_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !snp_ack); // R11
    AST_WB_WITH_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_wb |-> snp_supply); // R7
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.LINE_AW(LINE_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_ready (cpu_req_ready),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .bus_gnt       (bus_gnt),
    .bus_ack_all   (bus_ack_all),
    .snp_valid     (snp_valid),
    .snp_ack       (snp_ack),
    .snp_supply    (snp_supply),
    .snp_wb        (snp_wb)
);

// File: tb/msi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_test;
    localparam int AW = 12;
    localparam logic [1:0] RD = 2'b00, RDX = 2'b01, UPG = 2'b10, WB = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic cpu_req_ready, cpu_done, bus_req;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic bus_gnt = 1'b0, bus_ack_all = 1'b0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_ack, snp_supply, snp_wb;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0]    cmd;
        logic [AW-1:0] addr;
        string         tag;
    } bus_item_t;
    typedef struct {
        logic  sup;
        logic  wb;
        string tag;
    } snp_item_t;

    bus_item_t exp_bus[$];
    snp_item_t exp_snp[$];

    always #4 clk = ~clk;

    msi_snoop_ctrl #(.LINE_AW(AW), .IDX_W(3)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_ready(cpu_req_ready),
        .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_gnt(bus_gnt), .bus_ack_all(bus_ack_all),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_ack(snp_ack), .snp_supply(snp_supply), .snp_wb(snp_wb)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_bus(input logic [1:0] c, input logic [AW-1:0] a, input string tag);
        bus_item_t it;
        it.cmd = c; it.addr = a; it.tag = tag;
        exp_bus.push_back(it);
    endtask

    task automatic push_snp(input logic s, input logic w, input string tag);
        snp_item_t it;
        it.sup = s; it.wb = w; it.tag = tag;
        exp_snp.push_back(it);
    endtask

    // monitor: compares bus transfers and snoop responses with the queues
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (bus_req && bus_gnt && bus_ack_all) begin
                    if (exp_bus.size() == 0) begin
                        check(1'b0, "R5 R6 unexpected bus transfer", {bus_cmd, bus_addr}, 0);
                    end else begin
                        bus_item_t e;
                        e = exp_bus.pop_front();
                        check({bus_cmd, bus_addr} == {e.cmd, e.addr}, e.tag,
                              {bus_cmd, bus_addr}, {e.cmd, e.addr});
                    end
                end
                if (snp_ack) begin
                    if (exp_snp.size() == 0) begin
                        check(1'b0, "R11 unexpected snoop ack", 1, 0);
                    end else begin
                        snp_item_t e;
                        e = exp_snp.pop_front();
                        check({snp_supply, snp_wb} == {e.sup, e.wb}, e.tag,
                              {snp_supply, snp_wb}, {e.sup, e.wb});
                    end
                end
            end
        end
    end

    // core access with a simple arbiter; optional snoop while waiting for grant
    task automatic access(input bit wr, input logic [AW-1:0] a, input int exp_cyc,
                          input bit inj, input logic [1:0] icmd, input logic [AW-1:0] iaddr,
                          input string tag);
        int cyc;
        int wt;
        bit injected;
        cyc = 0; wt = 0; injected = 1'b0;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cyc = 1;
        while (!cpu_done && cyc < 200) begin
            snp_valid = 1'b0;
            if (bus_gnt) begin
                bus_gnt = 1'b0; bus_ack_all = 1'b0;
            end else if (bus_req) begin
                if (inj && !injected) begin
                    snp_valid = 1'b1; snp_cmd = icmd; snp_addr = iaddr;
                    injected = 1'b1; wt = 0;
                end else begin
                    wt++;
                    if (wt >= 2) begin
                        bus_gnt = 1'b1; bus_ack_all = 1'b1; wt = 0;
                    end
                end
            end
            @(negedge clk);
            cyc++;
        end
        snp_valid = 1'b0;
        check(cpu_done, {tag, " completion"}, cpu_done, 1);
        check(exp_bus.size() == 0, "R6 transfer finished before done", exp_bus.size(), 0);
        if (exp_cyc != 0) check(cyc == exp_cyc, {tag, " latency"}, cyc, exp_cyc);
        @(negedge clk);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                         input logic s, input logic w, input string tag);
        push_snp(s, w, tag);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        @(negedge clk);
        check(exp_snp.size() == 0, "R11 ack seen", exp_snp.size(), 0);
    endtask

    initial begin
        #(8 * 100000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_req_ready && !bus_req && !cpu_done && !snp_ack, "R1 reset outputs",
              {cpu_req_ready, bus_req, cpu_done, snp_ack}, 4'b1000);

        push_bus(RD, 12'h010, "R1 R2 R12 read miss");
        access(1'b0, 12'h010, 0, 1'b0, RD, '0, "R2 read miss");
        access(1'b0, 12'h010, 1, 1'b0, RD, '0, "R2 read hit Shared");

        push_bus(UPG, 12'h010, "R4 R12 upgrade on Shared store");
        access(1'b1, 12'h010, 0, 1'b0, RD, '0, "R4 store to Shared");
        access(1'b1, 12'h010, 1, 1'b0, RD, '0, "R5 store hit Modified");
        access(1'b0, 12'h010, 1, 1'b0, RD, '0, "R5 load hit Modified");

        snoop(RD, 12'h010, 1'b1, 1'b1, "R7 remote read of Modified");
        push_bus(UPG, 12'h010, "R7 line left Shared");
        access(1'b1, 12'h010, 0, 1'b0, RD, '0, "R7 store after remote read");

        snoop(RDX, 12'h010, 1'b1, 1'b0, "R8 remote ownership on Modified");
        push_bus(RD, 12'h010, "R8 line invalidated");
        access(1'b0, 12'h010, 0, 1'b0, RD, '0, "R8 reload");

        snoop(RD, 12'h010, 1'b0, 1'b0, "R9 remote read of Shared");
        access(1'b0, 12'h010, 1, 1'b0, RD, '0, "R9 still Shared");

        snoop(UPG, 12'h010, 1'b0, 1'b0, "R8 remote upgrade on Shared");
        push_bus(RD, 12'h010, "R8 reload after upgrade");
        access(1'b0, 12'h010, 0, 1'b0, RD, '0, "R8 reload");

        push_bus(RDX, 12'h021, "R3 R12 store miss");
        access(1'b1, 12'h021, 0, 1'b0, RD, '0, "R3 store miss");
        access(1'b1, 12'h021, 1, 1'b0, RD, '0, "R3 line Modified");

        push_bus(WB, 12'h021, "R10 R12 dirty victim written back");
        push_bus(RD, 12'h029, "R10 fill after write-back");
        access(1'b0, 12'h029, 0, 1'b0, RD, '0, "R10 dirty eviction");

        push_bus(RD, 12'h031, "R10 clean victim silent");
        access(1'b0, 12'h031, 0, 1'b0, RD, '0, "R10 clean eviction");

        snoop(RDX, 12'h055, 1'b0, 1'b0, "R9 snoop miss");
        access(1'b0, 12'h031, 1, 1'b0, RD, '0, "R9 unaffected line");

        push_snp(1'b0, 1'b0, "R13 remote ownership during wait");
        push_bus(RDX, 12'h031, "R13 upgrade becomes ownership read");
        access(1'b1, 12'h031, 0, 1'b1, RDX, 12'h031, "R13 lost Shared copy");
        access(1'b0, 12'h031, 1, 1'b0, RD, '0, "R13 line Modified");

        push_bus(WB, 12'h031, "R10 second dirty victim");
        push_bus(RDX, 12'h039, "R10 ownership fill");
        access(1'b1, 12'h039, 0, 1'b0, RD, '0, "R10 dirty eviction on store");

        repeat (3) @(negedge clk);
        check(exp_bus.size() == 0 && exp_snp.size() == 0, "R6 R11 queues drained",
              exp_bus.size() + exp_snp.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule